// File: doc/BRIEF.md
# Converter Sample Status Register

This block is a single 32-bit memory-mapped word that sits between a slow 8-bit converter and a processor bus. The converter sends a one-cycle strobe together with its 8-bit code. The register keeps the newest code and raises a data-ready flag. If a fresh code lands before software has read the previous one, it also raises a sticky overrun flag. Any bus read returns the whole word and clears both flags.

A standby bit is written over the bus and comes out of reset set. While it is set, the block ignores converter strobes and holds back the sample-rate tick. The tick comes from a divider that turns the system clock into roughly 304 pulses per second. It is meant to start each conversion.

Top module: `adc_status_reg`

## Requirements
- R1: Bits 31:24 of the read word are always 0x55.
- R2: After reset the word reads 0x55000001: code 0, ready 0, overrun 0, standby 1.
- R3: A strobe accepted while standby is 0 stores the code in bits 23:16 and sets ready (bit 1) from the next cycle.
- R4: A strobe accepted while ready is already 1, with no read in that cycle, sets overrun (bit 2). Overrun then stays set until a read.
- R5: A read returns the current word in the same cycle. From the next cycle, ready and overrun are 0.
- R6: If a read and an accepted strobe happen in the same cycle, the read returns the old word. Afterwards the new code is stored, ready is 1 and overrun is 0.
- R7: While standby is 1, strobes change nothing and the tick output stays low.
- R8: A write sets standby (bit 0) to write-data bit 0 from the next cycle. All other write-data bits have no effect.
- R9: While standby is 0, the tick pulses for one cycle every CLK_HZ/RATE_HZ cycles. The first pulse comes that many cycles after standby was cleared.
- R10: Bits 15:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe; clears the flags |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Register word |
| conv_strobe | input | 1 | New code from the converter |
| conv_code | input | 8 | Converter code |
| standby_o | output | 1 | Standby control to the converter |
| sample_tick_o | output | 1 | Conversion-start tick |

## Verification
The hardest case to reach is a read and a converter strobe in the same cycle while overrun is already set. Old flags must come back on the bus, yet the arriving code must survive. The bench builds up overrun with back-to-back strobes and then places a read exactly on the next strobe cycle. After that, a long run of random reads, strobes and standby writes is compared cycle by cycle against a behavioural model. That run reaches the same collision from many different flag states.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;

    localparam logic [7:0] SIGNATURE   = 8'h55;
    localparam logic       STANDBY_RST = 1'b1;

    typedef struct packed {
        logic [7:0] code;
        logic       missed;
        logic       ready;
    } sample_state_t;

    function automatic logic [31:0] pack_word(sample_state_t s, logic stby);
        return {SIGNATURE, s.code, 13'd0, s.missed, s.ready, stby};
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    p_tick_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tick);
    p_tick_single_r9: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/adc_sample_latch.sv
module adc_sample_latch
    import adc_stat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [7:0]    code_in,
    input  logic          rd_clr,
    output sample_state_t st
);
    sample_state_t nxt;

    always_comb begin
        nxt = st;
        if (take) begin
            nxt.code   = code_in;
            nxt.ready  = 1'b1;
            nxt.missed = rd_clr ? 1'b0 : (st.missed | st.ready);
        end else if (rd_clr) begin
            nxt.ready  = 1'b0;
            nxt.missed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    p_ready_set_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> st.ready && st.code == $past(code_in));
    p_missed_set_r4: assert property (@(posedge clk) disable iff (rst)
        take && st.ready && !rd_clr |=> st.missed);
    p_missed_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        st.missed && !rd_clr |=> st.missed);
    p_rd_clear_r5: assert property (@(posedge clk) disable iff (rst)
        rd_clr && !take |=> !st.ready && !st.missed);
    p_rd_race_r6: assert property (@(posedge clk) disable iff (rst)
        rd_clr && take |=> st.ready && !st.missed);
endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
    import adc_stat_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int RATE_HZ = 304
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        conv_strobe,
    input  logic [7:0]  conv_code,
    output logic        standby_o,
    output logic        sample_tick_o
);
    localparam int DIV = CLK_HZ / RATE_HZ;

    logic          stby_q;
    logic          take;
    sample_state_t st;

    always_ff @(posedge clk) begin
        if (rst)         stby_q <= STANDBY_RST;
        else if (bus_wr) stby_q <= bus_wdata[0];
    end

    assign take = conv_strobe && !stby_q;

    adc_sample_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .code_in (conv_code),
        .rd_clr  (bus_rd),
        .st      (st)
    );

    adc_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (!stby_q),
        .tick (sample_tick_o)
    );

    assign bus_rdata = pack_word(st, stby_q);
    assign standby_o = stby_q;

    p_stby_hold_r7: assert property (@(posedge clk) disable iff (rst)
        stby_q && !bus_rd |=> $stable(bus_rdata[23:1]));
    p_wr_bit0_r8: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> standby_o == $past(bus_wdata[0]));
    p_no_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(standby_o));
endmodule

// File: tb/adc_status_reg_tb_top.sv
module adc_status_reg_tb_top;
    localparam int CLK_HZ  = 3040;
    localparam int RATE_HZ = 304;
    localparam int DIV     = CLK_HZ / RATE_HZ;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_strobe = 1'b0;
    logic [7:0]  conv_code = '0;
    logic        standby_o, sample_tick_o;

    int checks = 0, errors = 0, cycles = 0;
    string tag = "R2";

    // behavioural reference state
    int m_code = 0, m_rdy = 0, m_mis = 0, m_stby = 1, m_cnt = 0;

    always #10 clk = ~clk;

    adc_status_reg #(.CLK_HZ(CLK_HZ), .RATE_HZ(RATE_HZ)) dut_i (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_strobe(conv_strobe), .conv_code(conv_code),
        .standby_o(standby_o), .sample_tick_o(sample_tick_o));

    function automatic logic [31:0] exp_word();
        return {8'h55, 8'(m_code), 13'd0, 1'(m_mis), 1'(m_rdy), 1'(m_stby)};
    endfunction

    task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int take;
        cycles++;
        if (rst) begin
            m_code = 0; m_rdy = 0; m_mis = 0; m_stby = 1; m_cnt = 0;
        end else begin
            take = (conv_strobe && m_stby == 0) ? 1 : 0;
            if (m_stby == 1) m_cnt = 0;
            else m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            if (take == 1) begin
                m_mis = bus_rd ? 0 : (m_mis | m_rdy);
                m_rdy = 1;
                m_code = int'(conv_code);
            end else if (bus_rd) begin
                m_rdy = 0; m_mis = 0;
            end
            if (bus_wr) m_stby = int'(bus_wdata[0]);
        end
    end

    // every-cycle comparison; R1 and R10 are covered by the word compare
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk({tag, " word (R1 R10)"}, bus_rdata, exp_word());
            chk({tag, " tick R9"}, {31'd0, sample_tick_o},
                {31'd0, 1'(m_stby == 0 && m_cnt == DIV - 1)});
            chk({tag, " standby"}, {31'd0, standby_o}, {31'd0, 1'(m_stby)});
        end
    end

    task automatic step(logic rd, logic wr, logic [31:0] wd, logic stb, logic [7:0] c);
        bus_rd = rd; bus_wr = wr; bus_wdata = wd; conv_strobe = stb; conv_code = c;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; conv_strobe = 0;
    endtask

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R2 reset word", bus_rdata, 32'h5500_0001);

        tag = "R7";
        step(0, 0, 0, 1, 8'hAA);
        chk("R7 strobe in standby", bus_rdata, 32'h5500_0001);
        chk("R7 tick low", {31'd0, sample_tick_o}, 32'd0);

        tag = "R8";
        step(0, 1, 32'hFFFF_FFFE, 0, 0);
        chk("R8 write only bit0", bus_rdata, 32'h5500_0000);

        tag = "R3";
        step(0, 0, 0, 1, 8'h12);
        chk("R3 latch+ready", bus_rdata, 32'h5512_0002);

        tag = "R4";
        step(0, 0, 0, 1, 8'h34);
        chk("R4 overrun", bus_rdata, 32'h5534_0006);
        step(0, 0, 0, 0, 0);
        chk("R4 sticky", bus_rdata, 32'h5534_0006);

        tag = "R6";
        bus_rd = 1; conv_strobe = 1; conv_code = 8'h56;
        #1 chk("R6 read sees old", bus_rdata, 32'h5534_0006);
        @(negedge clk);
        bus_rd = 0; conv_strobe = 0;
        chk("R6 new kept", bus_rdata, 32'h5556_0002);

        tag = "R5";
        bus_rd = 1;
        #1 chk("R5 read value", bus_rdata, 32'h5556_0002);
        @(negedge clk);
        bus_rd = 0;
        chk("R5 cleared", bus_rdata, 32'h5556_0000);

        tag = "R9";
        ticks = 0;
        for (int i = 0; i < 3 * DIV; i++) begin
            @(negedge clk);
            if (sample_tick_o) ticks++;
        end
        chk("R9 tick count", 32'(ticks), 32'd3);

        tag = "R7";
        step(0, 1, 32'h0000_0001, 0, 0);
        step(0, 0, 0, 1, 8'h99);
        chk("R7 ignored after re-entry", bus_rdata, 32'h5556_0001);

        tag = "R1";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2] & r[3] & r[4], {31'd0, r[5] & r[6]}, r[7], r[15:8]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=hang expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule